// File: doc/BRIEF.md
# Masked INT8 Attention Score Tile

This block produces a single attention logit from a 16-lane slice of a query vector and a 16-lane slice of a key vector. Every lane holds a signed 8-bit value. A one-cycle start strobe captures both slices, a Q15 scale factor and a causal mask bit. The block then forms the sixteen lane products and reduces them into a wide signed sum. That sum is never scaled or masked while it is being built. Only the output stage applies the scale factor. It then replaces the result with the most negative 32-bit value when the mask bit marks the position as disallowed.

A surrounding scheduler issues one start per tile and waits for the valid pulse. Softmax, sequencing across tiles and fetching operands are handled outside this block. The block holds the last score on its output until the next result replaces it. `busy` tells the scheduler when a new start would be accepted.

Top module: `attnScoreTile`

## Requirements
- R1: While reset is asserted and after it is released, `scoreValid` and `busy` are 0 and `score` is 0.
- R2: A start sampled while idle raises `busy` on the next cycle. `busy` stays high for two cycles, and `scoreValid` is high in the cycle after those two.
- R3: For an unmasked position, `score` equals S·C arithmetically shifted right by 15 and saturated to 32-bit signed. S is the exact signed sum of the 16 lane products, where lane i occupies bits [8i+7:8i] of `qVec` and `kVec`. C is `scaleQ15` read as a signed 16-bit value.
- R4: When the mask bit sampled with the start is 1, `score` is 32'h8000_0000 (the minimum signed 32-bit value), whatever the operands are.
- R5: `qVec`, `kVec`, `scaleQ15` and `maskIn` are sampled only with an accepted start. Changing them during the computation leaves the pending result unchanged.
- R6: A start received while `busy` is high is ignored. The pending result keeps its original operands and timing, and no second result follows.
- R7: `scoreValid` is a one-cycle pulse, and `score` holds its value in every cycle where `scoreValid` is low.
- R8: `busy` falls in the same cycle that `scoreValid` rises.
- R9: The sum does not overflow at the extreme operands. With all lanes -128 × -128 and scale 32767 the score is 262136. With all lanes -128 × 127 and scale -32768 it is 260096.
- R10: The right shift rounds toward minus infinity. A sum of -1 with scale 1 yields -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, accepted only while idle |
| qVec | input | 128 | Query slice, 16 signed 8-bit lanes, lane 0 in the low byte |
| kVec | input | 128 | Key slice, same packing as qVec |
| scaleQ15 | input | 16 | Signed Q15 scale factor |
| maskIn | input | 1 | 1 marks the position as causally masked |
| busy | output | 1 | Computation in progress |
| scoreValid | output | 1 | One-cycle flag marking a new score |
| score | output | 32 | Scaled, saturated, optionally masked logit |

## Verification
The checker assumes that `start` is a clean synchronous level free of X. It also assumes that the mask bit it mirrors is the one present on the cycle an idle start is accepted. Under those conditions the launch-to-valid timing and the forced minimum follow. The stimulus changes inputs only on falling edges and drives `start` for exactly one cycle per launch. The only exception is a deliberate second strobe while busy, which the checker's launch property also covers, because that property fires only on idle starts. Operand sweeps stay inside the signed 8-bit and signed Q15 ranges, so every expected score comes from plain integer arithmetic.

// File: rtl/attn_pkg.sv
package attn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SUM   = 2'd1,
    ST_SCALE = 2'd2
  } tileState_t;

  typedef struct packed {
    logic load;
    logic accumulate;
    logic emit;
  } ctrlStrobes_t;

endpackage

// File: rtl/attnScoreCtrl.sv
module attnScoreCtrl
  import attn_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t ctrl,
  output logic         busy,
  output logic         scoreValid
);

  tileState_t state;
  tileState_t stateNext;
  logic       validReg;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start) stateNext = ST_SUM;
      ST_SUM:   stateNext = ST_SCALE;
      ST_SCALE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl.load       = (state == ST_IDLE) && start;
    ctrl.accumulate = (state == ST_SUM);
    ctrl.emit       = (state == ST_SCALE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      validReg <= 1'b0;
    end else begin
      state    <= stateNext;
      validReg <= ctrl.emit;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign scoreValid = validReg;

endmodule

// File: rtl/attnScoreSat.sv
module attnScoreSat #(
  parameter int IN_W  = 22,
  parameter int OUT_W = 32
) (
  input  logic signed [IN_W-1:0]  valueIn,
  output logic signed [OUT_W-1:0] valueOut
);

  generate
    if (IN_W < OUT_W) begin : g_extend
      assign valueOut = {{(OUT_W-IN_W){valueIn[IN_W-1]}}, valueIn};
    end else if (IN_W == OUT_W) begin : g_pass
      assign valueOut = valueIn;
    end else begin : g_clamp
      localparam logic signed [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
      localparam logic signed [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};
      logic [IN_W-OUT_W:0] topBits;
      logic                fits;
      assign topBits = valueIn[IN_W-1:OUT_W-1];
      assign fits    = (&topBits) || (~|topBits);
      always_comb begin
        if (fits)               valueOut = valueIn[OUT_W-1:0];
        else if (valueIn[IN_W-1]) valueOut = MIN_V;
        else                    valueOut = MAX_V;
      end
    end
  endgenerate

endmodule

// File: rtl/attnScoreDatapath.sv
module attnScoreDatapath
  import attn_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int DATA_W  = 8,
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 15,
  parameter int OUT_W   = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            ctrl,
  input  logic [LANES*DATA_W-1:0] qVec,
  input  logic [LANES*DATA_W-1:0] kVec,
  input  logic [SCALE_W-1:0]      scaleQ15,
  input  logic                    maskIn,
  output logic [OUT_W-1:0]        score
);

  localparam int VEC_W = LANES * DATA_W;
  localparam int LP_W  = 2 * DATA_W;
  localparam int ACC_W = LP_W + $clog2(LANES) + 1;
  localparam int SP_W  = ACC_W + SCALE_W;
  localparam int SH_W  = SP_W - FRAC_W;
  localparam logic [OUT_W-1:0] MASK_V = {1'b1, {(OUT_W-1){1'b0}}};

  logic [VEC_W-1:0]          qReg;
  logic [VEC_W-1:0]          kReg;
  logic signed [SCALE_W-1:0] scaleReg;
  logic                      maskReg;
  logic signed [ACC_W-1:0]   accReg;
  logic signed [ACC_W-1:0]   laneSum;
  logic signed [LP_W-1:0]    laneProd [LANES];
  logic signed [SP_W-1:0]    scaledFull;
  logic signed [SH_W-1:0]    scaledShift;
  logic signed [OUT_W-1:0]   satValue;
  logic [OUT_W-1:0]          scoreReg;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign laneProd[g] = LP_W'($signed(qReg[g*DATA_W +: DATA_W]))
                         * LP_W'($signed(kReg[g*DATA_W +: DATA_W]));
    end
  endgenerate

  always_comb begin
    laneSum = '0;
    for (int i = 0; i < LANES; i++) begin
      laneSum = laneSum + {{(ACC_W-LP_W){laneProd[i][LP_W-1]}}, laneProd[i]};
    end
  end

  assign scaledFull  = SP_W'(accReg) * SP_W'(scaleReg);
  assign scaledShift = SH_W'(scaledFull >>> FRAC_W);

  attnScoreSat #(.IN_W(SH_W), .OUT_W(OUT_W)) u_sat (
    .valueIn (scaledShift),
    .valueOut(satValue)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReg     <= '0;
      kReg     <= '0;
      scaleReg <= '0;
      maskReg  <= 1'b0;
      accReg   <= '0;
      scoreReg <= '0;
    end else begin
      if (ctrl.load) begin
        qReg     <= qVec;
        kReg     <= kVec;
        scaleReg <= $signed(scaleQ15);
        maskReg  <= maskIn;
      end
      if (ctrl.accumulate) accReg <= laneSum;
      if (ctrl.emit) scoreReg <= maskReg ? MASK_V : satValue;
    end
  end

  assign score = scoreReg;

endmodule

// File: rtl/attnScoreTile.sv
module attnScoreTile
  import attn_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int DATA_W  = 8,
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 15,
  parameter int OUT_W   = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [LANES*DATA_W-1:0] qVec,
  input  logic [LANES*DATA_W-1:0] kVec,
  input  logic [SCALE_W-1:0]      scaleQ15,
  input  logic                    maskIn,
  output logic                    busy,
  output logic                    scoreValid,
  output logic [OUT_W-1:0]        score
);

  ctrlStrobes_t ctrl;

  attnScoreCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .ctrl      (ctrl),
    .busy      (busy),
    .scoreValid(scoreValid)
  );

  attnScoreDatapath #(
    .LANES(LANES), .DATA_W(DATA_W), .SCALE_W(SCALE_W),
    .FRAC_W(FRAC_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .qVec    (qVec),
    .kVec    (kVec),
    .scaleQ15(scaleQ15),
    .maskIn  (maskIn),
    .score   (score)
  );

endmodule

// File: rtl/attnScoreChk.sv
module attnScoreChk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             maskIn,
  input logic             busy,
  input logic             scoreValid,
  input logic [OUT_W-1:0] score
);

  localparam logic [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

  logic maskHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskHeld <= 1'b0;
    else if (start && !busy) maskHeld <= maskIn;
  end

  // R2
  launch_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy ##1 busy ##1 (scoreValid && !busy));

  // R4
  mask_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scoreValid && maskHeld) |-> (score == MIN_V));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    scoreValid |=> !scoreValid);

  // R7
  score_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !scoreValid |-> $stable(score));

  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scoreValid) |-> ($fell(busy)));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !busy);

endmodule

bind attnScoreTile attnScoreChk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .maskIn    (maskIn),
  .busy      (busy),
  .scoreValid(scoreValid),
  .score     (score)
);

// File: tb/test_attnScoreTile.sv
module test_attnScoreTile;

  localparam int LANES  = 16;
  localparam int DATA_W = 8;
  localparam int VEC_W  = LANES * DATA_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [VEC_W-1:0] qVec = '0;
  logic [VEC_W-1:0] kVec = '0;
  logic [15:0]      scaleQ15 = '0;
  logic             maskIn = 1'b0;
  logic             busy;
  logic             scoreValid;
  logic [31:0]      score;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  attnScoreTile i_attnScoreTile (
    .clk(clk), .rstN(rstN), .start(start), .qVec(qVec), .kVec(kVec),
    .scaleQ15(scaleQ15), .maskIn(maskIn), .busy(busy),
    .scoreValid(scoreValid), .score(score)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] mkVec(input int base, input int stride);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DATA_W +: DATA_W] = 8'(base + stride * i);
    return v;
  endfunction

  function automatic longint expScore(input logic [VEC_W-1:0] q, input logic [VEC_W-1:0] k,
                                      input logic [15:0] s, input logic m);
    longint acc;
    longint p;
    acc = 0;
    for (int i = 0; i < LANES; i++)
      acc += longint'($signed(q[i*DATA_W +: DATA_W])) * longint'($signed(k[i*DATA_W +: DATA_W]));
    p = acc * longint'($signed(s));
    p = p >>> 15;
    if (p > 64'sd2147483647) p = 64'sd2147483647;
    if (p < -64'sd2147483648) p = -64'sd2147483648;
    if (m) p = -64'sd2147483648;
    return p;
  endfunction

  // mode 0: plain, 1: disturb inputs after launch (R5), 2: restart while busy (R6)
  task automatic runOp(input logic [VEC_W-1:0] q, input logic [VEC_W-1:0] k,
                       input logic [15:0] s, input logic m, input int mode, input string tag);
    longint exp;
    exp = expScore(q, k, s, m);
    @(negedge clk);
    qVec = q; kVec = k; scaleQ15 = s; maskIn = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && scoreValid === 1'b0, "R2 busy after launch", busy, 1);
    if (mode != 0) begin
      qVec = ~q; kVec = ~k; scaleQ15 = ~s; maskIn = ~m;
      if (mode == 2) start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && scoreValid === 1'b0, "R2 busy second cycle", busy, 1);
    @(negedge clk);
    chk(scoreValid === 1'b1, "R2 valid timing", scoreValid, 1);
    chk(busy === 1'b0, "R8 busy drops with valid", busy, 0);
    chk(longint'($signed(score)) == exp, tag, longint'($signed(score)), exp);
    @(negedge clk);
    chk(scoreValid === 1'b0 && longint'($signed(score)) == exp,
        "R7 pulse and hold", longint'($signed(score)), exp);
    if (mode == 2) chk(busy === 1'b0, "R6 no second run", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scoreValid === 1'b0 && busy === 1'b0 && score === 32'd0, "R1 in reset", score, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(scoreValid === 1'b0 && busy === 1'b0 && score === 32'd0, "R1 after reset", score, 0);

    // R9 extremes
    runOp({LANES{8'h80}}, {LANES{8'h80}}, 16'sd32767, 1'b0, 0, "R9 max sum");
    chk(expScore({LANES{8'h80}}, {LANES{8'h80}}, 16'sd32767, 1'b0) == 262136,
        "R9 model", 0, 262136);
    runOp({LANES{8'h80}}, {LANES{8'h7f}}, 16'h8000, 1'b0, 0, "R9 min sum neg scale");
    // R10 floor rounding
    runOp(VEC_W'(8'hff), VEC_W'(8'h01), 16'd1, 1'b0, 0, "R10 floor of -1");
    // R4 masked extreme
    runOp({LANES{8'h7f}}, {LANES{8'h7f}}, 16'sd32767, 1'b1, 0, "R4 masked");
    // R5 disturbance, masked and unmasked
    runOp(mkVec(5, 37), mkVec(-90, 53), 16'sd20000, 1'b0, 1, "R5 inputs sampled");
    runOp(mkVec(-7, 11), mkVec(33, -29), 16'sd9000, 1'b1, 1, "R5 mask sampled");
    // R6 restart while busy
    runOp(mkVec(100, -3), mkVec(-100, 7), 16'sd32767, 1'b0, 2, "R6 restart ignored");

    // R3 / R4 sweep
    for (int a = 0; a < 256; a += 15) begin
      for (int b = 0; b < 256; b += 15) begin
        for (int si = 0; si < 5; si++) begin
          logic [15:0] s;
          logic m;
          case (si)
            0: s = 16'sd32767;
            1: s = 16'h8000;
            2: s = 16'sd16384;
            3: s = 16'sd1;
            default: s = 16'sd12345;
          endcase
          m = ((a + b + si) % 7) == 0;
          runOp(mkVec(a, 37), mkVec(b, -53), s, m, 0, m ? "R4 sweep masked" : "R3 sweep score");
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule